// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the serial front end of an EEPROM. It works as a mode-0 SPI slave. A faster system clock samples the chip select, serial clock, serial input and pause pins. The block decodes an opcode byte, a 16-bit address field and data bytes. It serves six commands against an internal byte array and a small status register:

- set the write-enable latch
- clear the write-enable latch
- read the status register
- write the status register
- read data
- write data

Read data leaves MSB first on the serial output. The bit changes after a falling serial clock, so the master can sample it on the next rising edge. The output enable is only active while the block is actually driving.

A pause pin suspends a transfer in the middle of a sequence without losing the position. The pause state only changes while the serial clock is low. Any completed data write or status write starts a self-timed internal write cycle when chip select rises. During that cycle only the status read is served.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Each command starts on a falling chip select, and its first byte is the opcode, MSB first. An opcode of the form 0000_b110 sets the latch and 0000_b100 clears it. The form 0000_b101 reads status, 0000_b001 writes status, 0000_b011 reads data and 0000_b010 writes data. The bit b (bit 3) is ignored.
- R2: Any other opcode byte makes the block ignore all further input, and keeps `so_oe` low until the next falling chip select.
- R3: A read takes a 16-bit address, MSB first, of which only the low AW bits are used. It then streams bytes from consecutive addresses, and the address wraps from the top address to 0.
- R4: The serial output changes only after a falling serial clock. `so_oe` is high only while chip select is low during the data phase of a read or a status read.
- R5: While paused, `so_oe` is low, serial clock edges are ignored and the sequence position is kept. The pause starts or ends only while the serial clock is low; pause is active when `hold_n` is low.
- R6: A data write or status write issued with the latch clear is ignored. It changes neither the array, the status register, nor the busy state.
- R7: A data write stores each received byte at the current address, which then increments and wraps over the whole array. On rising chip select after at least one stored byte, an internal cycle of WR_CYC clocks starts and the latch clears.
- R8: During the internal cycle every opcode except the status read is ignored. The status read returns 0xFF.
- R9: Outside the internal cycle, the status byte has these fields: bit 0 is busy (0 here), bit 1 is the latch, bits 3:2 are the protect field, bits 6:4 read 0 and bit 7 is the protect-enable flag. A status write stores bits 7, 3 and 2, then starts the internal cycle when chip select rises.
- R10: The set-latch opcode makes status bit 1 read 1, and the clear-latch opcode makes it read 0.
- R11: While chip select is high, `so_oe` is low and serial input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in, sampled on rising serial clock |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for the serial output |

## Verification
The tests use several kinds of command streams:

- Multi-byte writes and reads at a mid-array address show that address increment and byte ordering are correct.
- A write and read that start at the top address, sent with nonzero upper address bits, show wrapping and the don't-care upper bits. A read using the opcode with bit 3 set separates correct decoding from an exact-match decoder.
- Writes without the latch, and commands sent during the internal cycle, show that ignored input leaves the array and the status register unchanged. The status read returns 0xFF during that cycle.
- A read paused between bytes, with the serial clock toggling during the pause, tells a kept sequence position from a disturbed one.
- Invalid opcodes confirm that the output stays disabled for the rest of the selection.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int AW = 6,
  parameter int WR_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(WR_CYC + 1);
  localparam int SW = (AW - 1 > 7) ? AW - 1 : 7;
  localparam logic [2:0] PH_IDLE = 3'd0, PH_OPC = 3'd1, PH_ADR = 3'd2,
                         PH_DAT = 3'd3, PH_IGN = 3'd4;
  localparam logic [2:0] OP_SET = 3'b110, OP_CLR = 3'b100, OP_RDS = 3'b101,
                         OP_WRS = 3'b001, OP_RD = 3'b011, OP_WR = 3'b010;

  logic [1:0] cs_p, sck_p, si_p, hold_p;
  logic cs_d, sck_d;
  wire cs_s = cs_p[1];
  wire sck_s = sck_p[1];
  wire si_s = si_p[1];
  wire hold_s = hold_p[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= 2'b11; sck_p <= 2'b00; si_p <= 2'b00; hold_p <= 2'b11;
      cs_d <= 1'b1; sck_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[0], cs_n};
      sck_p <= {sck_p[0], sck};
      si_p <= {si_p[0], si};
      hold_p <= {hold_p[0], hold_n};
      cs_d <= cs_s;
      sck_d <= sck_s;
    end

  logic [2:0] ph, op;
  logic [3:0] cnt;
  logic [SW-1:0] sh;
  logic [AW-1:0] addr;
  logic [7:0] tx;
  logic so_q, xmit, paused, wel, wpen, pend;
  logic [1:0] bp;
  logic [CW-1:0] bcnt;
  logic [7:0] mem [DEPTH];

  wire busy = (bcnt != '0);
  wire cs_fall = ~cs_s & cs_d;
  wire cs_rise = cs_s & ~cs_d;
  wire live = ~cs_s & ~paused & (ph == PH_OPC || ph == PH_ADR || ph == PH_DAT);
  wire rx_edge = live & sck_s & ~sck_d;
  wire tx_edge = live & ~sck_s & sck_d;
  wire [7:0] byte_in = {sh[6:0], si_s};
  wire [AW-1:0] addr_in = {sh[AW-2:0], si_s};
  wire [AW-1:0] addr_nx = addr + 1'b1;
  wire [7:0] stat = busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};

  assign so = so_q;
  assign so_oe = ~cs_s & ~paused & xmit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= PH_IDLE; op <= '0; cnt <= '0; sh <= '0; addr <= '0; tx <= '0;
      so_q <= 1'b0; xmit <= 1'b0; paused <= 1'b0; wel <= 1'b0; wpen <= 1'b0;
      pend <= 1'b0; bp <= '0; bcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (cs_fall) begin
        ph <= PH_OPC; cnt <= '0; xmit <= 1'b0; paused <= 1'b0;
      end else if (cs_rise) begin
        ph <= PH_IDLE; xmit <= 1'b0; paused <= 1'b0;
        if (pend) begin
          pend <= 1'b0; wel <= 1'b0; bcnt <= CW'(WR_CYC);
        end
      end else begin
        if (!cs_s && !sck_s) paused <= ~hold_s;
        if (rx_edge) begin
          sh <= {sh[SW-2:0], si_s};
          cnt <= cnt + 1'b1;
          case (ph)
            PH_OPC: if (cnt == 4'd7) begin
              cnt <= '0;
              op <= byte_in[2:0];
              if (byte_in[7:4] != 4'd0 || (busy && byte_in[2:0] != OP_RDS))
                ph <= PH_IGN;
              else
                case (byte_in[2:0])
                  OP_SET: begin wel <= 1'b1; ph <= PH_IGN; end
                  OP_CLR: begin wel <= 1'b0; ph <= PH_IGN; end
                  OP_RDS: begin tx <= stat; xmit <= 1'b1; ph <= PH_DAT; end
                  OP_WRS: ph <= wel ? PH_DAT : PH_IGN;
                  OP_RD:  ph <= PH_ADR;
                  OP_WR:  ph <= wel ? PH_ADR : PH_IGN;
                  default: ph <= PH_IGN;
                endcase
            end
            PH_ADR: if (cnt == 4'd15) begin
              cnt <= '0;
              addr <= addr_in;
              ph <= PH_DAT;
              if (op == OP_RD) begin
                tx <= mem[addr_in];
                xmit <= 1'b1;
              end
            end
            PH_DAT: if (cnt == 4'd7) begin
              cnt <= '0;
              case (op)
                OP_RDS: tx <= stat;
                OP_RD: begin addr <= addr_nx; tx <= mem[addr_nx]; end
                OP_WR: begin mem[addr] <= byte_in; addr <= addr_nx; pend <= 1'b1; end
                default: begin
                  wpen <= byte_in[7]; bp <= byte_in[3:2]; pend <= 1'b1; ph <= PH_IGN;
                end
              endcase
            end
            default: ;
          endcase
        end
        if (tx_edge && xmit) so_q <= tx[3'd7 - cnt[2:0]];
      end
    end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so_oe,
  input logic cs_s,
  input logic sck_s,
  input logic sck_d,
  input logic paused,
  input logic [3:0] cnt,
  input logic [2:0] ph,
  input logic wel,
  input logic busy
);
  a_r11_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  a_r5_pause_keeps_position: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && sck_s && !sck_d && !cs_s) |=> $stable(cnt));

  a_r2_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd4 && !cs_s) |=> (ph == 3'd4 || ph == 3'd0));

  a_r8_no_latch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(wel));

  a_r7_latch_clear_at_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .cs_s(cs_s),
  .sck_s(sck_s), .sck_d(sck_d), .paused(paused), .cnt(cnt), .ph(ph),
  .wel(wel), .busy(busy)
);

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
  localparam int H = 8;
  localparam int WRC = 2000;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1;
  logic so, so_oe;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] r;

  spi_eeprom_slave #(.AW(6), .WR_CYC(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe));

  always #2 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 0; wait_clk(H);
  endtask

  task automatic desel();
    wait_clk(H); cs_n = 1; wait_clk(H);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      wait_clk(H);
      rx[i] = so;
      sck = 1;
      wait_clk(H);
      sck = 0;
    end
  endtask

  task automatic cmd1(input logic [7:0] opc);
    sel(); xfer(opc, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R11 oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(s);
    check("R9 status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s); check("R10 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); check("R10 latch clear", s, 8'h00);
    cmd1(8'h0E); rdsr(s); check("R1 set via bit3 form", s, 8'h02);
    cmd1(8'h0C); rdsr(s); check("R1 clear via bit3 form", s, 8'h00);
  endtask

  task automatic t_no_latch_write();
    logic [7:0] s, d;
    sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h05, r); xfer(8'hA5, r); desel();
    rdsr(s); check("R6 no cycle started", s, 8'h00);
    sel(); xfer(8'h01, r); xfer(8'h8C, r); desel();
    rdsr(s); check("R6 status write ignored", s, 8'h00);
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h05, r); xfer(8'h00, d); desel();
    check("R6 array unchanged", d, 8'h00);
  endtask

  task automatic t_write_busy_read();
    logic [7:0] s, d;
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h04, r);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); desel();
    rdsr(s); check("R8 status busy", s, 8'hFF);
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h04, r);
    check("R8 read ignored oe", {7'd0, so_oe}, 8'h00);
    xfer(8'h00, r); desel();
    cmd1(8'h06);
    wait_clk(WRC + 100);
    rdsr(s); check("R7 latch cleared, R8 set ignored", s, 8'h00);
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h04, r);
    xfer(8'h00, d); check("R3 first byte", d, 8'h11);
    check("R4 oe during read", {7'd0, so_oe}, 8'h01);
    xfer(8'h00, d); check("R3 increment", d, 8'h22);
    xfer(8'h00, d); check("R7 third byte", d, 8'h33);
    desel();
    check("R11 oe after deselect", {7'd0, so_oe}, 8'h00);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'hFF, r); xfer(8'h3F, r);
    xfer(8'h5A, r); xfer(8'hC3, r); desel();
    wait_clk(WRC + 100);
    sel(); xfer(8'h0B, r); xfer(8'h00, r); xfer(8'h3F, r);
    xfer(8'h00, d); check("R1 read via bit3 form, R3 top", d, 8'h5A);
    xfer(8'h00, d); check("R3 wrap to zero, R7 write wrap", d, 8'hC3);
    desel();
    sel(); xfer(8'h03, r); xfer(8'hC0, r); xfer(8'h00, r);
    xfer(8'h00, d); check("R3 upper address bits ignored", d, 8'hC3);
    desel();
  endtask

  task automatic t_invalid();
    logic [7:0] s;
    sel(); xfer(8'h07, r); xfer(8'h00, r);
    check("R2 oe low after 07", {7'd0, so_oe}, 8'h00);
    xfer(8'hFF, r); check("R2 still low", {7'd0, so_oe}, 8'h00);
    desel();
    sel(); xfer(8'h83, r); xfer(8'h00, r); xfer(8'h04, r); xfer(8'h00, r);
    check("R2 upper-nibble opcode ignored", {7'd0, so_oe}, 8'h00);
    desel();
    rdsr(s); check("R2 recovers on next select", s, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h04, r);
    hold_n = 0; wait_clk(H);
    check("R5 oe low while paused", {7'd0, so_oe}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      si = i[0]; sck = 1; wait_clk(H); sck = 0; wait_clk(H);
    end
    hold_n = 1; wait_clk(H);
    check("R5 oe back after pause", {7'd0, so_oe}, 8'h01);
    xfer(8'h00, d); check("R5 byte after pause", d, 8'h11);
    xfer(8'h00, d); check("R5 sequence kept", d, 8'h22);
    desel();
  endtask

  task automatic t_wrsr();
    logic [7:0] s;
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'hFC, r); desel();
    rdsr(s); check("R8 busy after status write", s, 8'hFF);
    wait_clk(WRC + 100);
    rdsr(s); check("R9 status fields stored", s, 8'h8C);
  endtask

  initial begin
    wait_clk(5); rst_n = 1; wait_clk(10);
    t_reset();
    t_latch();
    t_no_latch_write();
    t_write_busy_read();
    t_wrap();
    t_invalid();
    t_hold();
    t_wrsr();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule